// File: doc/BRIEF.md
# Active Antenna Power Supervisor

This block switches the supply of an active antenna on and off and watches two active-low status lines that come back from the antenna feed: one falls when the feed is shorted to ground, the other falls when DC current flows into the antenna, which means an antenna is present. Software asks for antenna power with a level request. The block turns the supply on and waits out a settling window. It then classifies the feed as healthy, open (no antenna) or shorted, and reports that as a two-bit status code. A one-cycle interrupt marks every change of that code.

A short cuts the supply at once and is held until software sends a retry strobe. The retry powers the feed again and restarts the settling window. While the supply is off, both status lines are expected to sit low; this is the normal unpowered state, so the lines are not evaluated then and never raise a fault. Both lines pass through a two-stage synchronizer and a debounce filter before the state machine uses them.

The supervisor has no enable of its own. It runs whenever it is out of reset.

State machine (states `ST_OFF`, `ST_BLANK`, `ST_RUN`, `ST_SHORT`):
- `ST_OFF` goes to `ST_BLANK` when the request is high.
- `ST_BLANK` goes to `ST_RUN` after the blanking window, or to `ST_OFF` if the request drops.
- `ST_RUN` goes to `ST_OFF` if the request drops. Otherwise it goes to `ST_SHORT` when the filtered short line is low.
- `ST_SHORT` goes to `ST_BLANK` on a retry while the request is high, or to `ST_OFF` on a retry while the request is low.

Top module: `ant_guard`

## Requirements
- R1: After reset, `pwr_en_o` is 0, `status_o` is OFF (2'b00) and `irq_o` is 0.
- R2: While the supply is off (`ST_OFF`), the two status lines are ignored: `status_o` stays OFF, `irq_o` stays 0 and `pwr_en_o` stays 0 until `pwr_req_i` is seen high. The clock edge that sees the request raises `pwr_en_o`.
- R3: After `pwr_en_o` rises, `status_o` stays OFF for exactly `BLANK_CYCLES` cycles (default 64), whatever the status lines do. On the next cycle the filtered lines are classified.
- R4: A status line is acted on only after its synchronized value has differed from the filtered value for `DEB_CYCLES` consecutive cycles (default 16). A shorter pulse has no effect.
- R5: With power on and evaluation active, if the short line is high then a low current line gives OK (2'b01) and a high current line gives OPEN (2'b11).
- R6: With evaluation active, a filtered low on the short line gives SHORT (2'b10) and drops `pwr_en_o` in the same cycle, whatever the current line shows. Both lines low together therefore count as a short.
- R7: SHORT and `pwr_en_o` = 0 are held whatever the status lines and the request do, until `retry_i` is seen. A retry while `pwr_req_i` is high raises `pwr_en_o` and starts a new blanking window with status OFF.
- R8: A low `pwr_req_i` turns the supply off on the next clock edge and gives status OFF. This takes priority over classification and over a retry in the same cycle.
- R9: `irq_o` is high for exactly the cycles in which `status_o` differs from its value in the previous cycle.
- R10: `retry_i` has no effect outside the SHORT state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pwr_req_i | input | 1 | Software request for antenna power (level) |
| retry_i | input | 1 | One-cycle strobe that clears a latched short |
| short_n_i | input | 1 | Short-circuit indication, low = feed shorted |
| cur_n_i | input | 1 | Antenna current indication, low = antenna present |
| pwr_en_o | output | 1 | Antenna supply switch, high = on |
| status_o | output | 2 | 00 OFF, 01 OK, 10 SHORT, 11 OPEN |
| irq_o | output | 1 | High in each cycle where the status code changed |

## Verification
Two events can fall in the same cycle: a retry strobe that releases a latched short, and software withdrawing its power request. The bench latches a short, then raises `retry_i` and lowers `pwr_req_i` at the same clock edge. It expects status OFF with `pwr_en_o` low right after that edge, and still low 80 cycles later, so no blanking window is ever started. A second coincidence is also covered: a retry pulse during normal operation is checked to leave the status code, the supply and the interrupt count unchanged.

// File: rtl/ant_guard_pkg.sv
package ant_guard_pkg;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_BLANK = 2'd1,
        ST_RUN   = 2'd2,
        ST_SHORT = 2'd3
    } ag_state_e;

    typedef enum logic [1:0] {
        STS_OFF   = 2'b00,
        STS_OK    = 2'b01,
        STS_SHORT = 2'b10,
        STS_OPEN  = 2'b11
    } ag_status_e;

    localparam int AG_NUM_IN    = 2;
    localparam int AG_IDX_SHORT = 0;
    localparam int AG_IDX_CUR   = 1;

endpackage

// File: rtl/ant_guard_filt.sv
// Two-flop synchronizer followed by a consecutive-cycle debounce filter.
module ant_guard_filt #(
    parameter int   DEB_CYCLES = 16,
    parameter logic RST_VAL    = 1'b1
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic raw_i,
    output logic flt_o
);
    localparam int CW = $clog2(DEB_CYCLES + 1);

    logic          meta_q, sync_q, flt_q;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            meta_q <= RST_VAL;
            sync_q <= RST_VAL;
        end else begin
            meta_q <= raw_i;
            sync_q <= meta_q;
        end
    end

    // Count cycles in which the synchronized level disagrees with the filtered one.
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
            flt_q <= RST_VAL;
        end else if (sync_q == flt_q) begin
            cnt_q <= '0;
        end else if (cnt_q == CW'(DEB_CYCLES - 1)) begin
            cnt_q <= '0;
            flt_q <= sync_q;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign flt_o = flt_q;

endmodule

// File: rtl/ant_guard_fsm.sv
module ant_guard_fsm
    import ant_guard_pkg::*;
#(
    parameter int BLANK_CYCLES = 64
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       pwr_req_i,
    input  logic       retry_i,
    input  logic       short_n_i,
    input  logic       cur_n_i,
    output logic       pwr_en_o,
    output ag_status_e status_o
);
    localparam int BW = $clog2(BLANK_CYCLES + 1);

    ag_state_e     state_q, state_d;
    logic [BW-1:0] blank_q;
    logic          blank_done;

    assign blank_done = (blank_q == BW'(BLANK_CYCLES - 1));

    // Blanking timer: cleared outside ST_BLANK, counts cycles inside it.
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                blank_q <= '0;
        else if (state_q != ST_BLANK) blank_q <= '0;
        else                        blank_q <= blank_q + 1'b1;
    end

    // State register.
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= ST_OFF;
        else         state_q <= state_d;
    end

    // Transitions.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF: begin
                if (pwr_req_i) state_d = ST_BLANK;
            end
            ST_BLANK: begin
                if (!pwr_req_i)      state_d = ST_OFF;
                else if (blank_done) state_d = ST_RUN;
            end
            ST_RUN: begin
                if (!pwr_req_i)      state_d = ST_OFF;
                else if (!short_n_i) state_d = ST_SHORT;
            end
            ST_SHORT: begin
                if (retry_i) state_d = pwr_req_i ? ST_BLANK : ST_OFF;
            end
        endcase
    end

    // Outputs.
    always_comb begin
        pwr_en_o = 1'b0;
        status_o = STS_OFF;
        unique case (state_q)
            ST_OFF: begin
                pwr_en_o = 1'b0;
                status_o = STS_OFF;
            end
            ST_BLANK: begin
                pwr_en_o = 1'b1;
                status_o = STS_OFF;
            end
            ST_RUN: begin
                pwr_en_o = 1'b1;
                status_o = cur_n_i ? STS_OPEN : STS_OK;
            end
            ST_SHORT: begin
                pwr_en_o = 1'b0;
                status_o = STS_SHORT;
            end
        endcase
    end

endmodule

// File: rtl/ant_guard_irq.sv
module ant_guard_irq
    import ant_guard_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  ag_status_e status_i,
    output logic       irq_o
);
    ag_status_e prev_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) prev_q <= STS_OFF;
        else         prev_q <= status_i;
    end

    assign irq_o = (status_i != prev_q);

endmodule

// File: rtl/ant_guard.sv
module ant_guard
    import ant_guard_pkg::*;
#(
    parameter int DEB_CYCLES   = 16,
    parameter int BLANK_CYCLES = 64
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       pwr_req_i,
    input  logic       retry_i,
    input  logic       short_n_i,
    input  logic       cur_n_i,
    output logic       pwr_en_o,
    output logic [1:0] status_o,
    output logic       irq_o
);
    logic [AG_NUM_IN-1:0] raw, flt;
    ag_status_e           status;

    assign raw[AG_IDX_SHORT] = short_n_i;
    assign raw[AG_IDX_CUR]   = cur_n_i;

    for (genvar g = 0; g < AG_NUM_IN; g++) begin : g_filt
        ant_guard_filt #(
            .DEB_CYCLES(DEB_CYCLES),
            .RST_VAL   (1'b1)
        ) i_filt (
            .clk_i (clk_i),
            .rst_ni(rst_ni),
            .raw_i (raw[g]),
            .flt_o (flt[g])
        );
    end

    ant_guard_fsm #(
        .BLANK_CYCLES(BLANK_CYCLES)
    ) i_fsm (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .pwr_req_i(pwr_req_i),
        .retry_i  (retry_i),
        .short_n_i(flt[AG_IDX_SHORT]),
        .cur_n_i  (flt[AG_IDX_CUR]),
        .pwr_en_o (pwr_en_o),
        .status_o (status)
    );

    ant_guard_irq i_irq (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .status_i(status),
        .irq_o   (irq_o)
    );

    assign status_o = status;

endmodule

// File: rtl/ant_guard_chk.sv
module ant_guard_chk #(
    parameter int BLANK_CYCLES = 64
) (
    input logic       clk_i,
    input logic       rst_ni,
    input logic       pwr_req_i,
    input logic       retry_i,
    input logic       pwr_en_o,
    input logic [1:0] status_o,
    input logic       irq_o
);
    localparam int          CW       = $clog2(BLANK_CYCLES + 1);
    localparam logic [1:0]  C_OFF    = 2'b00;
    localparam logic [1:0]  C_SHORT  = 2'b10;

    // Cycles since the supply came on, saturating at the blanking length.
    logic [CW-1:0] on_cnt_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                            on_cnt_q <= '0;
        else if (!pwr_en_o)                     on_cnt_q <= '0;
        else if (on_cnt_q != CW'(BLANK_CYCLES)) on_cnt_q <= on_cnt_q + 1'b1;
    end

    assert_reset_state_R1: assert property (@(posedge clk_i)
        !rst_ni |-> (!pwr_en_o && status_o == C_OFF && !irq_o));

    assert_blank_quiet_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pwr_en_o && on_cnt_q < CW'(BLANK_CYCLES)) |-> status_o == C_OFF);

    assert_pwr_rise_off_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(pwr_en_o) |-> status_o == C_OFF);

    assert_short_unpowered_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        status_o == C_SHORT |-> !pwr_en_o);

    assert_short_held_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (status_o == C_SHORT && !retry_i) |=> status_o == C_SHORT);

    assert_retry_repower_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (status_o == C_SHORT && retry_i && pwr_req_i) |=> (pwr_en_o && status_o == C_OFF));

    assert_req_drop_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !pwr_req_i |=> !pwr_en_o);

    assert_irq_on_change_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (status_o != $past(status_o)) |-> irq_o);

    assert_irq_only_change_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |-> (status_o != $past(status_o)));

endmodule

bind ant_guard ant_guard_chk #(
    .BLANK_CYCLES(BLANK_CYCLES)
) i_ant_guard_chk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .pwr_req_i(pwr_req_i),
    .retry_i  (retry_i),
    .pwr_en_o (pwr_en_o),
    .status_o (status_o),
    .irq_o    (irq_o)
);

// File: tb/test_ant_guard.sv
`timescale 1ns/1ps
module test_ant_guard;

    localparam logic [1:0] S_OFF   = 2'b00;
    localparam logic [1:0] S_OK    = 2'b01;
    localparam logic [1:0] S_SHORT = 2'b10;
    localparam logic [1:0] S_OPEN  = 2'b11;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pwr_req = 1'b0;
    logic       retry = 1'b0;
    logic       short_n = 1'b0;
    logic       cur_n = 1'b0;
    logic       pwr_en;
    logic [1:0] status;
    logic       irq;

    int checks = 0;
    int errors = 0;
    int irq_cnt = 0;

    always #2 clk = ~clk;

    ant_guard i_ant_guard (
        .clk_i    (clk),
        .rst_ni   (rst_n),
        .pwr_req_i(pwr_req),
        .retry_i  (retry),
        .short_n_i(short_n),
        .cur_n_i  (cur_n),
        .pwr_en_o (pwr_en),
        .status_o (status),
        .irq_o    (irq)
    );

    always @(negedge clk) if (rst_n && irq) irq_cnt <= irq_cnt + 1;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Let n rising edges pass, then settle at the following falling edge.
    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset;
        chk("R1 pwr_en", pwr_en, 0);
        chk("R1 status", status, S_OFF);
        chk("R1 irq", irq, 0);
    endtask

    task automatic t_off_ignore;
        int base = irq_cnt;
        short_n = 1'b0; cur_n = 1'b1; edges(25);
        short_n = 1'b0; cur_n = 1'b0;
        retry = 1'b1; edges(1); retry = 1'b0;   // R10: no effect while off
        edges(30);
        chk("R2 status off", status, S_OFF);
        chk("R2 pwr_en off", pwr_en, 0);
        chk("R2 no irq", irq_cnt - base, 0);
        chk("R10 retry off", pwr_en, 0);
    endtask

    task automatic t_power_on;
        short_n = 1'b1; cur_n = 1'b0; edges(30);
        pwr_req = 1'b1;
        edges(1);
        chk("R2 pwr_en on", pwr_en, 1);
        chk("R3 status start", status, S_OFF);
        edges(63);
        chk("R3 status end of blank", status, S_OFF);
        edges(1);
        chk("R5 ok", status, S_OK);
        chk("R9 irq pulse", irq, 1);
        edges(1);
        chk("R9 irq single", irq, 0);
    endtask

    task automatic t_open;
        cur_n = 1'b1;
        edges(15);
        chk("R4 not yet open", status, S_OK);
        edges(5);
        chk("R5 open", status, S_OPEN);
        cur_n = 1'b0; edges(8); cur_n = 1'b1;
        edges(30);
        chk("R4 glitch ignored", status, S_OPEN);
        cur_n = 1'b0;
        edges(20);
        chk("R5 back to ok", status, S_OK);
    endtask

    task automatic t_short_latch;
        short_n = 1'b0; cur_n = 1'b0;
        edges(16);
        chk("R4 short pending", status, S_OK);
        edges(4);
        chk("R6 short both low", status, S_SHORT);
        chk("R6 power cut", pwr_en, 0);
        short_n = 1'b1; cur_n = 1'b0;
        edges(40);
        chk("R7 short held", status, S_SHORT);
        chk("R7 power held off", pwr_en, 0);
        retry = 1'b1; edges(1); retry = 1'b0;
        chk("R7 retry repower", pwr_en, 1);
        chk("R7 retry blank", status, S_OFF);
        edges(65);
        chk("R7 ok after retry", status, S_OK);
    endtask

    task automatic t_retry_vs_drop;
        short_n = 1'b0; cur_n = 1'b1;
        edges(20);
        chk("R6 short cur high", status, S_SHORT);
        retry = 1'b1; pwr_req = 1'b0;
        edges(1);
        retry = 1'b0;
        chk("R8 retry with drop status", status, S_OFF);
        chk("R8 retry with drop pwr", pwr_en, 0);
        edges(80);
        chk("R8 stays off", pwr_en, 0);
    endtask

    task automatic t_run_retry_drop;
        int base;
        short_n = 1'b1; cur_n = 1'b0; edges(25);
        pwr_req = 1'b1; edges(70);
        chk("R5 ok again", status, S_OK);
        base = irq_cnt;
        retry = 1'b1; edges(1); retry = 1'b0;
        edges(2);
        chk("R10 retry run status", status, S_OK);
        chk("R10 retry run pwr", pwr_en, 1);
        chk("R10 retry run irq", irq_cnt - base, 0);
        pwr_req = 1'b0;
        edges(1);
        chk("R8 drop status", status, S_OFF);
        chk("R8 drop pwr", pwr_en, 0);
        chk("R9 drop irq", irq, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        edges(1);
        t_off_ignore();
        t_power_on();
        t_open();
        t_short_latch();
        t_retry_vs_drop();
        t_run_retry_drop();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule